// File: doc/BRIEF.md
# Audio Codec Control Register File

This block holds the 16-bit control and status words of an audio codec that a host reaches over a plain register port. The port has a 7-bit byte address (even addresses only), 16-bit write data, a write strobe and a registered 16-bit read bus. The implemented words are:

- a variable-rate control word;
- separate playback (DAC) and capture (ADC) sample-rate words;
- an identity word whose codec-slot bits come from two active-low strap pins;
- two fixed vendor words.

Every other address is reserved. A reserved address reads as zero, and writes to it are dropped.

The sample-rate words hold the rate in hertz as a plain binary number. They can only be changed while the variable-rate enable is set. While it is clear, both words read as 48000 Hz. A value written outside the supported 4000 to 48000 Hz range is clamped to the nearer limit.

Top module: `acodec_regfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rdata` becomes 0000h, the enable bit becomes 0, and both rate words return to BB80h (48000).
- R2: A read returns the addressed word on `rdata` one clock after `addr` is sampled. A write takes effect at the edge where `wr_en` is high, so a read at that same edge still shows the old value.
- R3: At address 2Ah, bit 0 is the variable-rate enable and can be read and written. Bits 15:1 read as 0.
- R4: With the enable set, a write to 2Ch (DAC rate) or 32h (ADC rate) stores the rate in hertz as a binary value, for example 1F40h for 8000 Hz.
- R5: A rate write below 4000 (0FA0h) stores 0FA0h. A rate write above 48000 (BB80h) stores BB80h.
- R6: While the enable is 0, writes to 2Ch and 32h are ignored and both addresses read BB80h. After the enable is cleared and set again, both words read BB80h.
- R7: Address 7Ch always reads 4E53h and address 7Eh always reads 4348h. Writes to them have no effect.
- R8: Address 28h is read-only. It reads as {~strap_n[1], ~strap_n[0], 13'b0, 1'b1}: bits 15:14 give the codec slot (00 primary, 01/10/11 secondary 1/2/3), and bit 0 advertises variable-rate support.
- R9: Any other address, including 24h, 5Ah, 74h, 7Ah and every odd address, reads 0000h. Writes to these addresses change no readable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| addr | input | 7 | Byte address of the word |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| strap_n | input | 2 | Active-low codec-slot strap pins |
| rdata | output | 16 | Registered read data |

## Verification
A wrong enable bit shows up within one read of 2Ah. It also shows up on the next read of either rate word, which then reads BB80h when it should not, or the reverse. A rate word that has lost its value, or was clamped wrongly, shows up on the first read of its address. A decode fault shows up as a wrong value one clock after the bad address is presented. The write and read traffic therefore mixes every address and crosses every clamp boundary, so that each stored bit is read back soon after any write that could disturb it.

// File: rtl/acodec_regfile.sv
module acodec_regfile #(
  parameter int unsigned RATE_MIN = 4000,
  parameter int unsigned RATE_MAX = 48000,
  parameter logic [15:0] VEND_HI  = 16'h4E53,
  parameter logic [15:0] VEND_LO  = 16'h4348
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  addr,
  input  logic [15:0] wdata,
  input  logic        wr_en,
  input  logic [1:0]  strap_n,
  output logic [15:0] rdata
);
  localparam logic [6:0]  A_ID   = 7'h28;
  localparam logic [6:0]  A_EXT  = 7'h2A;
  localparam logic [6:0]  A_DAC  = 7'h2C;
  localparam logic [6:0]  A_ADC  = 7'h32;
  localparam logic [6:0]  A_VHI  = 7'h7C;
  localparam logic [6:0]  A_VLO  = 7'h7E;
  localparam logic [15:0] R_MIN  = RATE_MIN[15:0];
  localparam logic [15:0] R_MAX  = RATE_MAX[15:0];

  logic        vra;
  logic [15:0] dac_rate, adc_rate, clamped, rd_mux;

  assign clamped = (wdata < R_MIN) ? R_MIN : (wdata > R_MAX) ? R_MAX : wdata;

  always_comb begin
    case (addr)
      A_ID:    rd_mux = {~strap_n, 13'b0, 1'b1};
      A_EXT:   rd_mux = {15'b0, vra};
      A_DAC:   rd_mux = vra ? dac_rate : R_MAX;
      A_ADC:   rd_mux = vra ? adc_rate : R_MAX;
      A_VHI:   rd_mux = VEND_HI;
      A_VLO:   rd_mux = VEND_LO;
      default: rd_mux = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vra      <= 1'b0;
      dac_rate <= R_MAX;
      adc_rate <= R_MAX;
      rdata    <= 16'h0000;
    end else begin
      rdata <= rd_mux;
      if (wr_en && addr == A_EXT) vra <= wdata[0];
      if (!vra) begin
        dac_rate <= R_MAX;
        adc_rate <= R_MAX;
      end else if (wr_en) begin
        if (addr == A_DAC) dac_rate <= clamped;
        if (addr == A_ADC) adc_rate <= clamped;
      end
    end
  end

  p_rate_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dac_rate >= R_MIN && dac_rate <= R_MAX && adc_rate >= R_MIN && adc_rate <= R_MAX);

  p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vra |=> (dac_rate == R_MAX && adc_rate == R_MAX));

  p_dac_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vra && wr_en && addr == A_DAC && wdata >= R_MIN && wdata <= R_MAX) |=> dac_rate == $past(wdata));

  p_vendor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr == A_VHI |=> rdata == VEND_HI);

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 7'h24 || addr == 7'h5A || addr == 7'h74 || addr == 7'h7A) |=> rdata == 16'h0000);

  p_ext_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_EXT) |=> $stable(vra));
endmodule

// File: tb/acodec_regfile_bench.sv
module acodec_regfile_bench;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [6:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [1:0]  strap_n = 2'b11;
  logic [15:0] rdata;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int m_vra = 0, m_dac = 48000, m_adc = 48000;
  int exp_q = 0;
  string tag_cur = "R1", tag_q = "R1";
  bit chk_en = 0;

  always #4 clk = ~clk;

  acodec_regfile u_acodec_regfile (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .strap_n(strap_n), .rdata(rdata));

  function automatic int clampv(int v);
    if (v < 4000) return 4000;
    if (v > 48000) return 48000;
    return v;
  endfunction

  function automatic int mread(int a);
    case (a)
      'h28: return ((3 - strap_n) << 14) | 1;
      'h2A: return m_vra;
      'h2C: return m_vra ? m_dac : 48000;
      'h32: return m_vra ? m_adc : 48000;
      'h7C: return 'h4E53;
      'h7E: return 'h4348;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      'h28: return "R8";
      'h2A: return "R3";
      'h2C, 'h32: return "R4";
      'h7C, 'h7E: return "R7";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      exp_q = 0; m_vra = 0; m_dac = 48000; m_adc = 48000;
    end else begin
      exp_q = mread(addr);
      if (!m_vra) begin m_dac = 48000; m_adc = 48000; end
      else if (wr_en) begin
        if (addr == 'h2C) m_dac = clampv(wdata);
        if (addr == 'h32) m_adc = clampv(wdata);
      end
      if (wr_en && addr == 'h2A) m_vra = wdata[0];
    end
    tag_q = tag_cur;
  end

  always @(negedge clk) if (chk_en) begin
    total++;
    if (rdata !== exp_q[15:0]) begin
      bad++;
      $display("FAIL %s: rdata=%h expected=%h at cycle %0d", tag_q, rdata, exp_q[15:0], cyc);
    end
  end

  task automatic step(input logic [6:0] a, input logic [15:0] d, input logic w, input string t);
    @(negedge clk);
    addr = a; wdata = d; wr_en = w; tag_cur = t;
  endtask

  task automatic finish_run();
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    chk_en = 1;
    tag_cur = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(7'h2A, 0, 0, "R1");
    step(7'h2C, 0, 0, "R1");
    step(7'h32, 0, 0, "R1");
    // R6: writes while disabled
    step(7'h2C, 16'h1F40, 1, "R6");
    step(7'h2C, 0, 0, "R6");
    // R3 enable
    step(7'h2A, 16'hFFFF, 1, "R3");
    step(7'h2A, 0, 0, "R3");
    // R2: write then same-edge read shows old value, next shows new
    step(7'h2C, 16'h1F40, 1, "R2");
    step(7'h2C, 0, 0, "R2");
    step(7'h32, 16'h5622, 1, "R4");
    step(7'h32, 0, 0, "R4");
    // R5 clamps
    step(7'h2C, 16'h0001, 1, "R5");
    step(7'h2C, 0, 0, "R5");
    step(7'h32, 16'hFFFF, 1, "R5");
    step(7'h32, 0, 0, "R5");
    step(7'h2C, 16'h0FA0, 1, "R5");
    step(7'h2C, 0, 0, "R5");
    step(7'h32, 16'hBB81, 1, "R5");
    step(7'h32, 0, 0, "R5");
    // R7 vendor words, write attempts
    step(7'h7C, 16'h0000, 1, "R7");
    step(7'h7C, 0, 0, "R7");
    step(7'h7E, 16'h1234, 1, "R7");
    step(7'h7E, 0, 0, "R7");
    // R8 strap pins
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); strap_n = s[1:0];
      step(7'h28, 16'hFFFF, 1, "R8");
      step(7'h28, 0, 0, "R8");
    end
    // R9 reserved writes then readback of live words
    step(7'h24, 16'hFFFF, 1, "R9");
    step(7'h5A, 16'hFFFF, 1, "R9");
    step(7'h74, 16'hFFFF, 1, "R9");
    step(7'h7A, 16'hFFFF, 1, "R9");
    step(7'h2D, 16'h0000, 1, "R9");
    step(7'h2D, 0, 0, "R9");
    step(7'h2C, 0, 0, "R9");
    step(7'h2A, 0, 0, "R9");
    // R6 disable and re-enable restores default
    step(7'h2A, 16'h0000, 1, "R6");
    step(7'h32, 0, 0, "R6");
    step(7'h2A, 16'h0001, 1, "R6");
    step(7'h2C, 0, 0, "R6");
    step(7'h32, 0, 0, "R6");
    // mixed traffic
    begin
      logic [15:0] lf = 16'hACE1;
      logic [6:0] pick [8] = '{7'h28, 7'h2A, 7'h2C, 7'h32, 7'h7C, 7'h7E, 7'h24, 7'h5A};
      for (int i = 0; i < 600; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(pick[lf[2:0]], {lf[7:0], lf[15:8]}, lf[5] & lf[9], tag_of(pick[lf[2:0]]));
        if (lf[4:0] == 5'd3) strap_n = lf[11:10];
      end
    end
    // R1 cold reset mid-run
    step(7'h2C, 16'h2B11, 1, "R1");
    @(negedge clk); rst_n = 0; wr_en = 0; tag_cur = "R1";
    @(negedge clk); rst_n = 1;
    step(7'h2A, 0, 0, "R1");
    step(7'h2C, 0, 0, "R1");
    step(7'h32, 0, 0, "R1");
    step(7'h00, 0, 0, "R1");
    @(negedge clk);
    done = 1;
    chk_en = 0;
    finish_run();
  end

  initial begin
    wait (cyc > 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: rdata=%h expected=%h", rdata, exp_q[15:0]);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule